// File: doc/BRIEF.md
# Intermittent Cycle-Steal DMA Throttle

This block governs bus ownership for a single DMA channel that works in cycle-steal fashion. The peripheral's request line is active low and is read as a level. While transfer units remain, the block raises a bus request. It holds that request until the arbiter grants the bus. It then flags an active transfer until the data path reports that the unit has finished. After every unit the bus goes back to the other master, so each unit is a separate bus tenure.

A two-bit mode input decides how soon the channel may compete for the bus again. In the normal modes the request can return one clock after the release. In the two intermittent modes a gap timer keeps the request low for a programmed minimum number of bus clocks, either a short gap or a long gap. This limits the share of bus time that DMA takes. A postpone input can hold back any request that is about to be issued. A unit counter is loaded by a strobe and counts tenures down. When it reaches zero, a done flag is set and the channel stays quiet until the counter is loaded again. The unit-size input does not change the timing. It is captured as a tag for each tenure.

Top module: `dma_steal_throttle`

## Requirements
- R1: After reset, bus_req, xfer_active and xfer_done are all 0.
- R2: The request is active low and level sensed. With units remaining, no postpone and req_n at 0 while the block is idle, bus_req rises on the next clock. While req_n is 1, bus_req stays 0.
- R3: bus_req stays high until a clock on which bus_grant is sampled high. The next cycle, bus_req is 0 and xfer_active is 1. xfer_active stays 1 up to and including the cycle in which unit_done is sampled, then falls. bus_req and xfer_active are never high together.
- R4: With mode_sel 2'b00 or 2'b01 (normal) and req_n held low, bus_req rises exactly 1 clock after xfer_active falls.
- R5: With mode_sel 2'b10 at unit end and req_n held low, bus_req rises exactly GAP_SHORT (16) clocks after xfer_active falls, and never sooner.
- R6: With mode_sel 2'b11 at unit end and req_n held low, bus_req rises exactly GAP_LONG (64) clocks after xfer_active falls, and never sooner.
- R7: If req_n goes low only after the gap has expired, bus_req rises on the next clock.
- R8: While postpone is 1, bus_req is not raised. It rises one clock after postpone returns to 0 if the request is still pending.
- R9: Each finished unit lowers the remaining count by one. When a unit finishes with one unit left, xfer_done becomes 1 and no bus request is raised while it is set.
- R10: A load_en pulse with a nonzero load_count clears xfer_done on the next clock, and a pending request raises bus_req one clock after that.
- R11: active_size takes the unit_size value present when bus_req rises and holds it until the next rise of bus_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 1 | Transfer request, active low level |
| mode_sel | input | 2 | 00/01 normal, 10 short gap, 11 long gap |
| unit_size | input | SIZE_W | Transfer-unit size tag |
| load_en | input | 1 | Load strobe for the remaining-unit counter |
| load_count | input | CNT_W | Number of units to transfer |
| bus_grant | input | 1 | Bus grant from the arbiter |
| unit_done | input | 1 | Current unit has completed |
| postpone | input | 1 | Stall that holds back a new bus request |
| bus_req | output | 1 | Bus request |
| xfer_active | output | 1 | Channel owns the bus for one unit |
| xfer_done | output | 1 | All units transferred |
| active_size | output | SIZE_W | Size tag of the current tenure |

## Verification
The release-to-request distance is measured with req_n held low in each of the four mode codes. This separates the one-clock return of the normal modes from the 16 and 64 clock holds, and shows that the reserved code acts as normal. A request that is withdrawn during the gap and reasserted late shows that the timer does not delay a request that arrives after it has expired. A postpone held across an idle request shows that the stall alone blocks the request. A late grant confirms that the request is held. Counts of two and one cover the done flag and the reload.

// File: rtl/dma_thr_pkg.sv
package dma_thr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2,
    ST_GAP  = 2'd3
  } thr_state_e;

  // Intermittent modes are the two codes with the upper bit set.
  function automatic logic is_intermittent(input logic [1:0] mode);
    return mode[1];
  endfunction

  // The lower bit picks the long gap inside the intermittent pair.
  function automatic logic is_long_gap(input logic [1:0] mode);
    return mode[1] & mode[0];
  endfunction

endpackage

// File: rtl/dma_thr_gap_timer.sv
module dma_thr_gap_timer #(
  parameter int GAP_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [GAP_W-1:0] start_val,
  output logic             expired
);

  logic [GAP_W-1:0] cnt_q;
  logic [GAP_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    cnt_d  = start ? start_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/dma_thr_unit_counter.sv
module dma_thr_unit_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_count,
  input  logic             unit_end,
  output logic             units_left,
  output logic             done
);

  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] rem_d;
  logic             rem_en;
  logic             done_q;
  logic             done_d;
  logic             done_en;

  always_comb begin
    rem_en  = load_en || (unit_end && (rem_q != '0));
    rem_d   = load_en ? load_count : rem_q - 1'b1;
    done_en = load_en || (unit_end && (rem_q == CNT_W'(1)));
    done_d  = !load_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (rem_en) begin
      rem_q <= rem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else if (done_en) begin
      done_q <= done_d;
    end
  end

  assign units_left = (rem_q != '0);
  assign done       = done_q;

endmodule

// File: rtl/dma_thr_fsm.sv
module dma_thr_fsm
  import dma_thr_pkg::*;
#(
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_n,
  input  logic              postpone,
  input  logic              units_left,
  input  logic              intermittent,
  input  logic              bus_grant,
  input  logic              unit_done,
  input  logic              gap_expired,
  input  logic [SIZE_W-1:0] unit_size,
  output logic              gap_start,
  output logic              unit_end,
  output logic              bus_req,
  output logic              xfer_active,
  output logic [SIZE_W-1:0] active_size
);

  thr_state_e        state_q;
  thr_state_e        state_d;
  logic              go;
  logic              size_en;
  logic [SIZE_W-1:0] size_q;

  always_comb begin
    go      = !req_n && !postpone && units_left;
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (go) state_d = ST_REQ;
      ST_REQ:  if (bus_grant) state_d = ST_XFER;
      ST_XFER: if (unit_done) state_d = intermittent ? ST_GAP : ST_IDLE;
      ST_GAP:  if (gap_expired) state_d = go ? ST_REQ : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    unit_end  = (state_q == ST_XFER) && unit_done;
    gap_start = unit_end && intermittent;
    size_en   = (state_d == ST_REQ) && (state_q != ST_REQ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
    end else if (size_en) begin
      size_q <= unit_size;
    end
  end

  assign bus_req     = (state_q == ST_REQ);
  assign xfer_active = (state_q == ST_XFER);
  assign active_size = size_q;

endmodule

// File: rtl/dma_steal_throttle.sv
module dma_steal_throttle
  import dma_thr_pkg::*;
#(
  parameter int GAP_SHORT = 16,
  parameter int GAP_LONG  = 64,
  parameter int CNT_W     = 16,
  parameter int SIZE_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_n,
  input  logic [1:0]        mode_sel,
  input  logic [SIZE_W-1:0] unit_size,
  input  logic              load_en,
  input  logic [CNT_W-1:0]  load_count,
  input  logic              bus_grant,
  input  logic              unit_done,
  input  logic              postpone,
  output logic              bus_req,
  output logic              xfer_active,
  output logic              xfer_done,
  output logic [SIZE_W-1:0] active_size
);

  localparam int GAP_W = $clog2(GAP_LONG + 1);
  localparam logic [GAP_W-1:0] SHORT_LOAD = GAP_W'(GAP_SHORT - 1);
  localparam logic [GAP_W-1:0] LONG_LOAD  = GAP_W'(GAP_LONG - 1);

  logic             intermittent;
  logic [GAP_W-1:0] gap_load;
  logic             gap_start;
  logic             gap_expired;
  logic             unit_end;
  logic             units_left;

  always_comb begin
    intermittent = is_intermittent(mode_sel);
    gap_load     = is_long_gap(mode_sel) ? LONG_LOAD : SHORT_LOAD;
  end

  dma_thr_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (gap_start),
    .start_val (gap_load),
    .expired   (gap_expired)
  );

  dma_thr_unit_counter #(.CNT_W(CNT_W)) u_units (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .load_count (load_count),
    .unit_end   (unit_end),
    .units_left (units_left),
    .done       (xfer_done)
  );

  dma_thr_fsm #(.SIZE_W(SIZE_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_n        (req_n),
    .postpone     (postpone),
    .units_left   (units_left),
    .intermittent (intermittent),
    .bus_grant    (bus_grant),
    .unit_done    (unit_done),
    .gap_expired  (gap_expired),
    .unit_size    (unit_size),
    .gap_start    (gap_start),
    .unit_end     (unit_end),
    .bus_req      (bus_req),
    .xfer_active  (xfer_active),
    .active_size  (active_size)
  );

endmodule

// File: rtl/dma_thr_checker.sv
module dma_thr_checker #(
  parameter int GAP_SHORT = 16,
  parameter int GAP_LONG  = 64,
  parameter int SIZE_W    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_sel,
  input logic              bus_grant,
  input logic              unit_done,
  input logic              bus_req,
  input logic              xfer_active,
  input logic              xfer_done,
  input logic [SIZE_W-1:0] active_size
);

  // Clocks since the channel released the bus, saturating.
  logic [7:0] since_rel;
  logic [1:0] mode_at_rel;
  logic       seen_rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rel   <= '0;
      mode_at_rel <= '0;
      seen_rel    <= 1'b0;
    end else begin
      if (xfer_active) begin
        since_rel <= '0;
      end else if (since_rel != 8'hff) begin
        since_rel <= since_rel + 8'd1;
      end
      if (xfer_active && unit_done) begin
        mode_at_rel <= mode_sel;
        seen_rel    <= 1'b1;
      end
    end
  end

  p_hold_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_grant |=> bus_req);

  p_grant_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_grant |=> xfer_active && !bus_req);

  p_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && xfer_active));

  p_short_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) && seen_rel && mode_at_rel == 2'b10 |-> since_rel >= 8'(GAP_SHORT));

  p_long_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) && seen_rel && mode_at_rel == 2'b11 |-> since_rel >= 8'(GAP_LONG));

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !bus_req);

  p_size_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_active |-> $stable(active_size));

endmodule

bind dma_steal_throttle dma_thr_checker #(
  .GAP_SHORT (GAP_SHORT),
  .GAP_LONG  (GAP_LONG),
  .SIZE_W    (SIZE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_sel    (mode_sel),
  .bus_grant   (bus_grant),
  .unit_done   (unit_done),
  .bus_req     (bus_req),
  .xfer_active (xfer_active),
  .xfer_done   (xfer_done),
  .active_size (active_size)
);

// File: tb/dma_steal_throttle_test.sv
`timescale 1ns/1ps
module dma_steal_throttle_test;

  localparam int CLK_PERIOD = 10;
  localparam int SIZE_W = 3;
  localparam int CNT_W  = 16;

  logic              clk;
  logic              rst_n;
  logic              req_n;
  logic [1:0]        mode_sel;
  logic [SIZE_W-1:0] unit_size;
  logic              load_en;
  logic [CNT_W-1:0]  load_count;
  logic              bus_grant;
  logic              unit_done;
  logic              postpone;
  logic              bus_req;
  logic              xfer_active;
  logic              xfer_done;
  logic [SIZE_W-1:0] active_size;

  int checks;
  int fails;
  int cycles;

  dma_steal_throttle uut (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .mode_sel(mode_sel),
    .unit_size(unit_size), .load_en(load_en), .load_count(load_count),
    .bus_grant(bus_grant), .unit_done(unit_done), .postpone(postpone),
    .bus_req(bus_req), .xfer_active(xfer_active), .xfer_done(xfer_done),
    .active_size(active_size)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Wait for bus_req (bounded), hold grant off for 'delay' clocks, grant,
  // then finish the unit. Returns with xfer_active just fallen.
  task automatic run_unit(input int delay, input string tag);
    int w = 0;
    while (!bus_req && w < 200) begin @(negedge clk); w++; end
    chk(bus_req == 1'b1, {tag, " R2 bus_req present"}, bus_req, 1);
    for (int i = 0; i < delay; i++) begin
      @(negedge clk);
      chk(bus_req == 1'b1, "R3 bus_req held without grant", bus_req, 1);
    end
    bus_grant = 1'b1;
    @(negedge clk);
    bus_grant = 1'b0;
    chk(xfer_active == 1'b1, "R3 xfer_active after grant", xfer_active, 1);
    chk(bus_req == 1'b0, "R3 bus_req dropped after grant", bus_req, 0);
    @(negedge clk);
    chk(xfer_active == 1'b1, "R3 xfer_active held until unit_done", xfer_active, 1);
    unit_done = 1'b1;
    @(negedge clk);
    unit_done = 1'b0;
    chk(xfer_active == 1'b0, "R3 xfer_active fell after unit_done", xfer_active, 0);
  endtask

  // Clocks from the fall of xfer_active to the rise of bus_req.
  task automatic measure_gap(output int n);
    n = 0;
    while (!bus_req && n < 300) begin @(negedge clk); n++; end
  endtask

  task automatic test_reset();
    chk(bus_req == 1'b0, "R1 bus_req after reset", bus_req, 0);
    chk(xfer_active == 1'b0, "R1 xfer_active after reset", xfer_active, 0);
    chk(xfer_done == 1'b0, "R1 xfer_done after reset", xfer_done, 0);
  endtask

  task automatic test_level_req();
    load_count = 16'd1000; load_en = 1'b1;
    @(negedge clk); load_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(bus_req == 1'b0, "R2 no request while req_n high", bus_req, 0);
    req_n = 1'b0;
    @(negedge clk);
    chk(bus_req == 1'b1, "R2 request one clock after req_n low", bus_req, 1);
  endtask

  task automatic test_normal(input logic [1:0] m, input string tag);
    int n;
    mode_sel = m;
    run_unit(2, tag);
    measure_gap(n);
    chk(n == 1, {"R4 normal-mode gap ", tag}, n, 1);
  endtask

  task automatic test_inter(input logic [1:0] m, input int exp, input string tag);
    int n;
    mode_sel = m;
    run_unit(0, tag);
    measure_gap(n);
    chk(n == exp, tag, n, exp);
  endtask

  task automatic test_late_req();
    mode_sel = 2'b10;
    run_unit(0, "R7");
    req_n = 1'b1;
    repeat (30) @(negedge clk);
    chk(bus_req == 1'b0, "R7 no request after gap without req", bus_req, 0);
    req_n = 1'b0;
    @(negedge clk);
    chk(bus_req == 1'b1, "R7 late request one clock", bus_req, 1);
  endtask

  task automatic test_postpone_size();
    mode_sel = 2'b00;
    run_unit(0, "R8");
    postpone = 1'b1;
    unit_size = 3'd5;
    repeat (5) @(negedge clk);
    chk(bus_req == 1'b0, "R8 postpone blocks request", bus_req, 0);
    postpone = 1'b0;
    @(negedge clk);
    chk(bus_req == 1'b1, "R8 request after postpone released", bus_req, 1);
    chk(active_size == 3'd5, "R11 size captured at request", active_size, 5);
    unit_size = 3'd1;
    bus_grant = 1'b1;
    @(negedge clk);
    bus_grant = 1'b0;
    chk(active_size == 3'd5, "R11 size held during tenure", active_size, 5);
    unit_done = 1'b1;
    @(negedge clk);
    unit_done = 1'b0;
    @(negedge clk);
    chk(active_size == 3'd1, "R11 size recaptured at next request", active_size, 1);
  endtask

  task automatic test_done_reload();
    mode_sel = 2'b00;
    load_count = 16'd2; load_en = 1'b1;
    @(negedge clk); load_en = 1'b0;
    run_unit(0, "R9 first");
    chk(xfer_done == 1'b0, "R9 not done with one left", xfer_done, 0);
    run_unit(0, "R9 second");
    chk(xfer_done == 1'b1, "R9 done after last unit", xfer_done, 1);
    repeat (10) @(negedge clk);
    chk(bus_req == 1'b0, "R9 no request while done", bus_req, 0);
    load_count = 16'd1; load_en = 1'b1;
    @(negedge clk); load_en = 1'b0;
    chk(xfer_done == 1'b0, "R10 done cleared by load", xfer_done, 0);
    chk(bus_req == 1'b0, "R10 no request on load clock", bus_req, 0);
    @(negedge clk);
    chk(bus_req == 1'b1, "R10 request after reload", bus_req, 1);
  endtask

  initial begin
    checks = 0; fails = 0; cycles = 0;
    rst_n = 1'b0; req_n = 1'b1; mode_sel = 2'b00; unit_size = 3'd2;
    load_en = 1'b0; load_count = '0; bus_grant = 1'b0; unit_done = 1'b0;
    postpone = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_level_req();
    test_normal(2'b00, "mode 00");
    test_normal(2'b01, "mode 01 reserved");
    test_inter(2'b10, 16, "R5 short gap");
    test_inter(2'b11, 64, "R6 long gap");
    test_inter(2'b10, 16, "R5 short gap after long");
    test_late_req();
    test_postpone_size();
    test_done_reload();
    finish_run();
  end

endmodule